// File: doc/BRIEF.md
# Asynchronous Serial Port with Sticky Framing-Error Flag

This block is a full-duplex asynchronous serial port with two register addresses, for an 8-bit processor subsystem. A write to the data address loads a transmit shift register and starts a frame on `txd`. A read of the same address returns a separate receive buffer, so both directions run at the same time. The control address holds the frame-format bits, receive enable, the ninth transmit and receive bits, and the two completion flags TI and RI. The `irq` output is the OR of the two flags. Bit timing comes from `sample_tick`, a one-cycle pulse at sixteen times the bit rate. Baud generation lies outside the block.

The frame format follows the two format bits. When the top format bit (bit 7) is 0, a frame has eight data bits. When it is 1, a ninth bit follows the data. The `fe_sel` pin changes what control bit 7 is. When `fe_sel` is 0, bit 7 is the top format bit. When `fe_sel` is 1, bit 7 is a sticky framing-error flag, and the format bit underneath keeps its value. Turning on framing-error detection also moves the RI event: RI is set at the stop-bit sample instead of at the last data-bit sample.

The register port has no back-pressure. Every write is taken in the cycle it is presented, and reads are combinational. A data write during an active frame restarts the transmitter with the new frame, so software waits for TI before it writes again.

Top module: `uart_fe_core`

## Requirements
- R1: After reset, `txd` is 1, `irq` is 0, and both the control register and the receive buffer read 0x00.
- R2: A data write starts a frame. The frame is one low start bit, then the data bits LSB first, then one high stop bit, and each bit lasts 16 sample ticks. When control bit 7 is 1 (format bit, `fe_sel` = 0), control bit 3 (TB8) is sent as a ninth data bit before the stop bit.
- R3: TI (control bit 1) is set when the stop bit starts on `txd`. TI and RI (bit 0) stay set until software writes 0 to them. `irq` is high exactly when TI or RI is set.
- R4: A receive frame starts on a low line only while receive enable (control bit 4) is 1. Each bit is judged by a majority vote of sample ticks 7, 8 and 9 of that bit. A start bit that votes 1 is dropped as a false start, and no flag changes.
- R5: The received data byte is read at the data address (`reg_sel` = 1). In nine-bit format, the ninth received bit is stored in RB8 (control bit 2).
- R6: With `fe_sel` = 0, RI is set at the vote of the last data bit. With `fe_sel` = 1, RI is set one bit later, at the stop-bit vote.
- R7: With `fe_sel` = 1, a stop bit that votes 0 sets FE. A later valid stop bit does not clear FE, and writing 1 to it has no effect. Only a control write with bit 7 = 0 while `fe_sel` = 1 clears it.
- R8: Control bit 7 reads and writes the top format bit when `fe_sel` = 0, and the FE flag when `fe_sel` = 1. A control write made while `fe_sel` = 1 leaves the format bit unchanged. Bit 6 is the low format bit, and bit 5 reads 0.
- R9: When a hardware set of TI or RI lands in the same cycle as a software write of 0 to that flag, the flag ends up set.
- R10: A transmit frame and a receive frame in flight at the same time both complete correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| fe_sel | input | 1 | 1 selects the framing-error flag in control bit 7 and moves RI to the stop bit |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = data register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| rxd | input | 1 | Serial receive line (asynchronous) |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | TI OR RI |

## Verification
Two functions can fall in the same cycle: the transmitter raising TI at the start of the stop bit, and a software control write that clears TI. The bench sends an all-zero byte, so the first rising edge of `txd` marks the stop bit. It then writes control with TI = 0 in the very next cycle and expects TI to read 1 afterwards. A second overlap starts a transmit while a receive frame is arriving. The two scoreboards then check that both frames come through intact and that the receive monitor's register accesses do not disturb the transmit side.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
  // control register bit positions
  localparam int CB_TOP  = 7;  // format bit 1 or FE, per fe_sel
  localparam int CB_MS1  = 6;
  localparam int CB_RXEN = 4;
  localparam int CB_TB8  = 3;
  localparam int CB_RB8  = 2;
  localparam int CB_TI   = 1;
  localparam int CB_RI   = 0;

  typedef struct packed {
    logic [7:0] data;
    logic       bit9;
  } rx_word_t;
endpackage

// File: rtl/uart_fe_tx.sv
module uart_fe_tx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start,
  input  logic       nine,
  input  logic [7:0] data,
  input  logic       tb8,
  output logic       txd,
  output logic       stop_pulse
);
  localparam int CW = $clog2(OVS);

  logic [10:0]   sh;
  logic          busy;
  logic [CW-1:0] cnt;
  logic [3:0]    idx;
  logic [3:0]    stop_idx;

  assign stop_idx = nine ? 4'd10 : 4'd9;
  assign txd      = sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh         <= '1;
      busy       <= 1'b0;
      cnt        <= '0;
      idx        <= '0;
      stop_pulse <= 1'b0;
    end else begin
      stop_pulse <= 1'b0;
      if (start) begin
        sh   <= {1'b1, (nine ? tb8 : 1'b1), data, 1'b0};
        busy <= 1'b1;
        cnt  <= '0;
        idx  <= '0;
      end else if (busy && tick) begin
        if (cnt == CW'(OVS - 1)) begin
          cnt <= '0;
          if (idx == stop_idx) begin
            busy <= 1'b0;
            sh   <= '1;
          end else begin
            sh  <= {1'b1, sh[10:1]};
            idx <= idx + 4'd1;
            if (idx + 4'd1 == stop_idx) stop_pulse <= 1'b1;
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  // R2: line rests high outside a frame
  a_r2_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  // R3: the TI event coincides with a high stop bit on the line
  a_r3_stop_pulse_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |-> (txd && busy));
endmodule

// File: rtl/uart_fe_rx.sv
module uart_fe_rx
  import uart_fe_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     rxd_raw,
  input  logic     en,
  input  logic     nine,
  input  logic     fe_en,
  output logic     done,
  output logic     bad_stop,
  output rx_word_t word
);
  localparam int CW  = $clog2(OVS);
  localparam int MID = OVS / 2;

  logic          sync1, rxd_s;
  logic          busy;
  logic [CW-1:0] cnt;
  logic [3:0]    idx;
  logic          sa, sb, vote;
  logic [8:0]    sh, sh_nx;
  logic [3:0]    last_data;

  assign last_data = nine ? 4'd9 : 4'd8;
  assign vote      = (sa & sb) | (sa & rxd_s) | (sb & rxd_s);
  assign sh_nx     = {vote, sh[8:1]};

  function automatic rx_word_t pick(input logic [8:0] s, input logic n9);
    rx_word_t w;
    if (n9) begin
      w.data = s[7:0];
      w.bit9 = s[8];
    end else begin
      w.data = s[8:1];
      w.bit9 = 1'b0;
    end
    return w;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      rxd_s <= 1'b1;
    end else begin
      sync1 <= rxd_raw;
      rxd_s <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      idx      <= '0;
      sa       <= 1'b1;
      sb       <= 1'b1;
      sh       <= '0;
      done     <= 1'b0;
      bad_stop <= 1'b0;
      word     <= '0;
    end else begin
      done     <= 1'b0;
      bad_stop <= 1'b0;
      if (!busy) begin
        if (tick && en && !rxd_s) begin
          busy <= 1'b1;
          cnt  <= CW'(1);
          idx  <= '0;
        end
      end else if (tick) begin
        if (cnt == CW'(OVS - 1)) begin
          cnt <= '0;
          idx <= idx + 4'd1;
        end else begin
          cnt <= cnt + CW'(1);
        end
        if (cnt == CW'(MID - 1)) sa <= rxd_s;
        if (cnt == CW'(MID))     sb <= rxd_s;
        if (cnt == CW'(MID + 1)) begin
          if (idx == 4'd0) begin
            if (vote) busy <= 1'b0;           // false start
          end else if (idx <= last_data) begin
            sh <= sh_nx;
            if (idx == last_data && !fe_en) begin
              done <= 1'b1;
              word <= pick(sh_nx, nine);
            end
          end else begin
            busy <= 1'b0;                     // stop bit judged, re-arm
            if (fe_en) begin
              done     <= 1'b1;
              word     <= pick(sh, nine);
              bad_stop <= !vote;
            end
          end
        end
      end
    end
  end

  // R4: a frame only begins while reception is enabled
  a_r4_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en));
  // R7: a bad stop is only reported together with frame completion
  a_r7_bad_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    bad_stop |-> done);
endmodule

// File: rtl/uart_fe_core.sv
module uart_fe_core
  import uart_fe_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_tick,
  input  logic       fe_sel,
  input  logic       reg_wr,
  input  logic       reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       irq
);
  logic     ctrl_wr, data_wr;
  logic     ms0, ms1, rxen, tb8, rb8, ti, ri, fe;
  logic [7:0] rxbuf;
  logic     tx_stop, rx_done, rx_bad;
  rx_word_t rx_word;
  logic     unused_wbit;

  assign ctrl_wr     = reg_wr && !reg_sel;
  assign data_wr     = reg_wr &&  reg_sel;
  assign unused_wbit = reg_wdata[5];

  uart_fe_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .start(data_wr),
    .nine(ms0), .data(reg_wdata), .tb8(tb8), .txd(txd), .stop_pulse(tx_stop)
  );

  uart_fe_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .rxd_raw(rxd), .en(rxen),
    .nine(ms0), .fe_en(fe_sel), .done(rx_done), .bad_stop(rx_bad), .word(rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms0 <= 1'b0; ms1 <= 1'b0; rxen <= 1'b0; tb8 <= 1'b0;
      rb8 <= 1'b0; ti  <= 1'b0; ri   <= 1'b0; fe  <= 1'b0;
      rxbuf <= '0;
    end else begin
      if (ctrl_wr) begin
        if (!fe_sel) ms0 <= reg_wdata[CB_TOP];
        ms1  <= reg_wdata[CB_MS1];
        rxen <= reg_wdata[CB_RXEN];
        tb8  <= reg_wdata[CB_TB8];
      end
      // hardware events take priority over a same-cycle software write
      if (tx_stop)      ti <= 1'b1;
      else if (ctrl_wr) ti <= reg_wdata[CB_TI];
      if (rx_done)      ri <= 1'b1;
      else if (ctrl_wr) ri <= reg_wdata[CB_RI];
      if (rx_done && ms0) rb8 <= rx_word.bit9;
      else if (ctrl_wr)   rb8 <= reg_wdata[CB_RB8];
      if (rx_bad) fe <= 1'b1;
      else if (ctrl_wr && fe_sel && !reg_wdata[CB_TOP]) fe <= 1'b0;
      if (rx_done) rxbuf <= rx_word.data;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_sel) begin
      reg_rdata = rxbuf;
    end else begin
      reg_rdata[CB_TOP]  = fe_sel ? fe : ms0;
      reg_rdata[CB_MS1]  = ms1;
      reg_rdata[CB_RXEN] = rxen;
      reg_rdata[CB_TB8]  = tb8;
      reg_rdata[CB_RB8]  = rb8;
      reg_rdata[CB_TI]   = ti;
      reg_rdata[CB_RI]   = ri;
    end
  end

  assign irq = ti | ri;

  // R7: FE holds unless cleared by a software write of 0 under fe_sel
  a_r7_fe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fe && !(ctrl_wr && fe_sel && !reg_wdata[CB_TOP])) |=> fe);
  // R3 / R9: the stop-bit event always leaves TI set
  a_r9_ti_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stop |=> ti);
  // R6 / R9: a completed frame always leaves RI set
  a_r9_ri_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> ri);
  // R8: writes under fe_sel leave the format bit alone
  a_r8_format_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && fe_sel) |=> $stable(ms0));
endmodule

// File: tb/tb_uart_fe_core.sv
`timescale 1ns/1ps
module tb_uart_fe_core;
  logic clk = 1'b0, rst_n = 1'b0, sample_tick = 1'b0, fe_sel = 1'b0;
  logic reg_wr = 1'b0, reg_sel = 1'b0, rxd = 1'b1;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic txd, irq;

  always #2.5 clk = ~clk;

  uart_fe_core dut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .fe_sel(fe_sel),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rxd(rxd), .txd(txd), .irq(irq)
  );

  typedef struct {
    logic [7:0] data;
    logic       b9;
    logic       nine;
    logic       fe_chk;
    logic       fe_exp;
    string      tag;
  } item_t;

  item_t rxq[$];
  item_t txq[$];
  int checks = 0, errors = 0;
  int cyc = 0;
  int t0 = 0;
  int irq_rise_cyc = 0;
  bit irq_rise_pend = 0;
  bit bus_lock = 0;
  logic irq_prev = 1'b0;
  logic [1:0] tdiv = '0;

  always @(posedge clk) cyc <= cyc + 1;

  initial forever begin
    @(negedge clk);
    tdiv = tdiv + 2'd1;
    sample_tick = (tdiv == 2'd0);
  end

  always @(negedge clk) begin
    if (irq && !irq_prev) begin
      irq_rise_cyc  = cyc;
      irq_rise_pend = 1;
    end
    irq_prev = irq;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_win(input string req, input string what, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic lock();
    while (bus_lock) @(negedge clk);
    bus_lock = 1;
  endtask

  task automatic wr_reg(input logic sel, input logic [7:0] v);
    lock();
    @(negedge clk);
    reg_sel = sel; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    bus_lock = 0;
  endtask

  task automatic rd_reg(input logic sel, output logic [7:0] v);
    lock();
    @(negedge clk);
    reg_sel = sel;
    #1 v = reg_rdata;
    bus_lock = 0;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic b9, input logic nine, input logic stopv);
    @(negedge clk);
    t0 = cyc;
    rxd = 1'b0;
    repeat (64) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (64) @(negedge clk);
    end
    if (nine) begin
      rxd = b9;
      repeat (64) @(negedge clk);
    end
    rxd = stopv;
    repeat (64) @(negedge clk);
    rxd = 1'b1;
    repeat (64) @(negedge clk);
  endtask

  task automatic push_rx(input logic [7:0] d, input logic b9, input logic nine,
                         input logic fc, input logic fx, input string tag);
    item_t it;
    it.data = d; it.b9 = b9; it.nine = nine; it.fe_chk = fc; it.fe_exp = fx; it.tag = tag;
    rxq.push_back(it);
  endtask

  task automatic send_tx(input logic [7:0] d, input logic b9, input logic nine, input string tag);
    item_t it;
    it.data = d; it.b9 = b9; it.nine = nine; it.fe_chk = 0; it.fe_exp = 0; it.tag = tag;
    txq.push_back(it);
    wr_reg(1'b1, d);
  endtask

  // receive-side monitor: on each irq rise, service RI and score the frame
  initial forever begin
    logic [7:0] c, d;
    item_t it;
    @(negedge clk);
    if (irq_rise_pend) begin
      irq_rise_pend = 0;
      rd_reg(1'b0, c);
      if (c[0]) begin
        rd_reg(1'b1, d);
        if (rxq.size() == 0) begin
          chk("R5", "unexpected receive frame", {24'h0, d}, 32'hFFFF_FFFF);
        end else begin
          it = rxq.pop_front();
          chk(it.tag, "received data", {24'h0, d}, {24'h0, it.data});
          if (it.nine) chk("R5", "RB8", {31'h0, c[2]}, {31'h0, it.b9});
          if (it.fe_chk) chk("R7", "FE after frame", {31'h0, c[7]}, {31'h0, it.fe_exp});
        end
        wr_reg(1'b0, c & 8'hFE);
      end
    end
  end

  // transmit-side monitor: decode each frame at mid-bit and score it
  initial forever begin
    logic [8:0] got;
    item_t it;
    @(negedge clk);
    if (rst_n && txd === 1'b0) begin
      got = '0;
      repeat (32) @(negedge clk);
      if (txq.size() == 0) begin
        chk("R2", "unexpected transmit frame", 32'h0, 32'hFFFF_FFFF);
      end else begin
        it = txq.pop_front();
        chk("R2", "start bit level", {31'h0, txd}, 32'h0);
        for (int i = 0; i < 8; i++) begin
          repeat (64) @(negedge clk);
          got[i] = txd;
        end
        if (it.nine) begin
          repeat (64) @(negedge clk);
          got[8] = txd;
          chk("R2", "ninth bit (TB8)", {31'h0, got[8]}, {31'h0, it.b9});
        end
        repeat (64) @(negedge clk);
        chk(it.tag, "transmitted data", {24'h0, got[7:0]}, {24'h0, it.data});
        chk("R2", "stop bit level", {31'h0, txd}, 32'h1);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1", "txd at reset", {31'h0, txd}, 32'h1);
    chk("R1", "irq at reset", {31'h0, irq}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_reg(1'b0, v); chk("R1", "control at reset", {24'h0, v}, 32'h00);
    rd_reg(1'b1, v); chk("R1", "rx buffer at reset", {24'h0, v}, 32'h00);

    // 8-bit format, receive enabled; R8 bit 5 reads 0
    wr_reg(1'b0, 8'h70);
    rd_reg(1'b0, v); chk("R8", "control readback", {24'h0, v}, 32'h50);

    // R2 / R3 transmit and TI
    send_tx(8'hA5, 1'b0, 1'b0, "R2");
    repeat (800) @(negedge clk);
    rd_reg(1'b0, v); chk("R3", "TI after frame", {31'h0, v[1]}, 32'h1);
    chk("R3", "irq with TI", {31'h0, irq}, 32'h1);
    wr_reg(1'b0, 8'h50);
    repeat (2) @(negedge clk);
    chk("R3", "irq after TI clear", {31'h0, irq}, 32'h0);

    // R5 / R6 receive 8-bit, RI at last data bit
    push_rx(8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    send_frame(8'h3C, 1'b0, 1'b0, 1'b1);
    chk_win("R6", "RI delay fe off", irq_rise_cyc - t0, 545, 560);
    wait (rxq.size() == 0); repeat (20) @(negedge clk);

    // R4 receive disabled: frame ignored
    wr_reg(1'b0, 8'h40);
    send_frame(8'hFF, 1'b0, 1'b0, 1'b1);
    rd_reg(1'b0, v); chk("R4", "RI with receive disabled", {31'h0, v[0]}, 32'h0);
    chk("R4", "irq with receive disabled", {31'h0, irq}, 32'h0);
    wr_reg(1'b0, 8'h50);

    // R4 false start: short low glitch rejected, next frame fine
    @(negedge clk); rxd = 1'b0;
    repeat (8) @(negedge clk); rxd = 1'b1;
    repeat (200) @(negedge clk);
    rd_reg(1'b0, v); chk("R4", "RI after glitch", {31'h0, v[0]}, 32'h0);
    push_rx(8'h96, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
    send_frame(8'h96, 1'b0, 1'b0, 1'b1);
    wait (rxq.size() == 0); repeat (20) @(negedge clk);

    // 9-bit format (bit7 = 1), TB8 = 1
    wr_reg(1'b0, 8'h98);
    send_tx(8'h5A, 1'b1, 1'b1, "R2");
    repeat (900) @(negedge clk);
    wr_reg(1'b0, 8'h98);
    push_rx(8'hC1, 1'b1, 1'b1, 1'b0, 1'b0, "R5");
    send_frame(8'hC1, 1'b1, 1'b1, 1'b1);
    push_rx(8'h0F, 1'b0, 1'b1, 1'b0, 1'b0, "R5");
    send_frame(8'h0F, 1'b0, 1'b1, 1'b1);
    wait (rxq.size() == 0); repeat (20) @(negedge clk);

    // R8 / R7 framing-error view
    @(negedge clk); fe_sel = 1'b1;
    rd_reg(1'b0, v); chk("R8", "bit7 shows FE", {24'h0, v}, 32'h18);
    wr_reg(1'b0, 8'h98);
    rd_reg(1'b0, v); chk("R7", "write 1 leaves FE clear", {31'h0, v[7]}, 32'h0);
    push_rx(8'h81, 1'b0, 1'b1, 1'b1, 1'b1, "R7");
    send_frame(8'h81, 1'b0, 1'b1, 1'b0);
    chk_win("R6", "RI delay fe on", irq_rise_cyc - t0, 672, 690);
    wait (rxq.size() == 0); repeat (20) @(negedge clk);
    push_rx(8'h42, 1'b1, 1'b1, 1'b1, 1'b1, "R7");
    send_frame(8'h42, 1'b1, 1'b1, 1'b1);
    wait (rxq.size() == 0); repeat (20) @(negedge clk);
    rd_reg(1'b0, v); chk("R7", "FE after valid stop", {31'h0, v[7]}, 32'h1);
    wr_reg(1'b0, 8'h18);
    rd_reg(1'b0, v); chk("R7", "FE cleared by write 0", {31'h0, v[7]}, 32'h0);
    @(negedge clk); fe_sel = 1'b0;
    rd_reg(1'b0, v); chk("R8", "format bit kept", {24'h0, v}, 32'h98);

    // R9 TI set and software clear in the same cycle (8-bit, all zeros)
    wr_reg(1'b0, 8'h50);
    send_tx(8'h00, 1'b0, 1'b0, "R9");
    lock();
    do @(negedge clk); while (txd !== 1'b1);
    reg_sel = 1'b0; reg_wdata = 8'h50; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    bus_lock = 0;
    rd_reg(1'b0, v); chk("R9", "TI after collision", {31'h0, v[1]}, 32'h1);
    repeat (100) @(negedge clk);
    wr_reg(1'b0, 8'h50);

    // R10 full duplex
    push_rx(8'hC3, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
    fork
      send_frame(8'hC3, 1'b0, 1'b0, 1'b1);
      begin
        repeat (100) @(negedge clk);
        send_tx(8'h3C, 1'b0, 1'b0, "R10");
      end
    join
    wait (rxq.size() == 0 && txq.size() == 0);
    repeat (300) @(negedge clk);
    rd_reg(1'b0, v); chk("R10", "TI after duplex", {31'h0, v[1]}, 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule